// File: doc/BRIEF.md
# Register Cache with Dead-Value Invalidation

This block is a small write-back register cache that sits between the execution units and a slow backing register file. Every register write from the execution units lands in the cache. The backing file is touched only when a conflict miss displaces a line that still holds a live, modified value, or when a read misses and must fetch a value. The cache is direct-mapped. Its set index is a hash of warp number and register number. Each line holds one register for all lanes of a warp.

Every operand read request carries two source registers and a two-bit last-reference vector, which an upstream filter stage supplies. A set bit means this read is the final consumer of that operand's register. When the read completes, the cache drops the matching line without writing it back. A dead value therefore never costs a slow backing-file write. Two counters report the write-backs performed and the dirty lines discarded by this mechanism.

The backing-file port is a level request held until a one-cycle acknowledge. The backing file answers after a fixed number of cycles. The cache lowers `ready` while a write-back or fill is outstanding, and while it is serving a read.

Top module: `regcache_dvi`

## Requirements
- R1: After synchronous reset, every line is invalid, `ready` is 1, `bf_req` is 0 and both counters are 0.
- R2: An accepted write whose register is already resident, or whose set holds an invalid or clean line, updates the cache in the accepting cycle and produces no backing-file request. A later read of that register returns the written data with no fill.
- R3: When a write or a read miss finds its set occupied by a valid dirty line of another register, that line is written to the backing file once, at address {warp, reg}, before the new value is installed. `wb_count` then increases by one.
- R4: A read miss issues a backing-file read (`bf_we`=0) at address {warp, reg} and returns the fetched data. The line is installed clean, so evicting it later causes no write-back.
- R5: The set index is reg[2:0] XOR {1'b0, warp}. The full {warp, reg} pair is the tag, so two registers sharing a set displace each other.
- R6: When `rd_last` bit i (bit 0 for `rd_reg0`, bit 1 for `rd_reg1`) is set and that register's line is still resident at completion, the line becomes invalid after `rd_done` and is never written back. If the line was dirty, `wb_avoided` increases by one. A later read fetches the older backing-file value.
- R7: If both operands name the same register and either last-reference bit is set, both operands return the same data. The line is invalidated once, and `wb_avoided` rises by at most one.
- R8: `ready` is 0 whenever `bf_req` is 1. `bf_req` and `bf_addr` stay steady until `bf_ack`.
- R9: When `wr_valid` and `rd_valid` are both high with `ready` high, the write is accepted first. The read, held until accepted, observes the written data.
- R10: Operands are served in order, operand 0 and then operand 1. `rd_data0` and `rd_data1` are valid in the single cycle that `rd_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write from execution units |
| wr_warp | input | 2 | Warp of the written register |
| wr_reg | input | 4 | Register number written |
| wr_data | input | 64 | Data for all lanes (2 x 32) |
| rd_valid | input | 1 | Operand read request |
| rd_warp | input | 2 | Warp of the read |
| rd_reg0 | input | 4 | First source register |
| rd_reg1 | input | 4 | Second source register |
| rd_last | input | 2 | Last-reference flags, bit i for operand i |
| ready | output | 1 | Cache idle; accepts a request |
| rd_done | output | 1 | Read complete, data valid |
| rd_data0 | output | 64 | Operand 0 data |
| rd_data1 | output | 64 | Operand 1 data |
| bf_req | output | 1 | Backing-file request |
| bf_we | output | 1 | 1 = write-back, 0 = fill |
| bf_addr | output | 6 | {warp, reg} |
| bf_wdata | output | 64 | Write-back data |
| bf_ack | input | 1 | Backing-file completion |
| bf_rdata | input | 64 | Fill data, valid with bf_ack |
| wb_count | output | 16 | Write-backs performed |
| wb_avoided | output | 16 | Dirty lines dropped by invalidation |

## Verification
The bench pairs registers that collide in one set so that each write or fill must evict the other. A design that skipped the eviction write-back would leave stale data in the backing file. A design that wrote back clean lines would show extra backing writes. A last-reference read on a dirty line, followed by a re-read, shows whether the line was really discarded: a design that wrote it back returns the new value instead of the old backing value. A read with the same register in both operand slots exposes double invalidation through a double count. Simultaneous write and read of one register catch a reversed priority, which would return stale data.

// File: rtl/regcache_pkg.sv
package regcache_pkg;
    localparam int WARP_W = 2;
    localparam int REG_W  = 4;
    localparam int LANES  = 2;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 3;
    localparam int SETS   = 1 << IDX_W;
    localparam int LINE_W = LANES * WORD_W;
    localparam int ADDR_W = WARP_W + REG_W;

    typedef logic [WARP_W-1:0] warp_t;
    typedef logic [REG_W-1:0]  rnum_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        warp_t             warp;
        rnum_t             rnum;
        logic [LINE_W-1:0] data;
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP,
        ST_WB,
        ST_FILL,
        ST_FIN
    } st_t;

    function automatic idx_t set_of(warp_t w, rnum_t r);
        return r[IDX_W-1:0] ^ IDX_W'(w);
    endfunction

    function automatic logic holds(line_t l, warp_t w, rnum_t r);
        return l.valid && (l.warp == w) && (l.rnum == r);
    endfunction
endpackage

// File: rtl/regcache_store.sv
module regcache_store
    import regcache_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  idx_t            widx,
    input  line_t           wline,
    input  logic [1:0]      clr,
    input  idx_t [1:0]      cidx,
    output line_t           lines [SETS]
);
    for (genvar g = 0; g < SETS; g++) begin : g_set
        line_t q;
        logic  hit_w, hit_c;
        assign hit_w = we && (widx == IDX_W'(g));
        assign hit_c = (clr[0] && (cidx[0] == IDX_W'(g))) ||
                       (clr[1] && (cidx[1] == IDX_W'(g)));
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit_w) begin
                q <= wline;
            end else if (hit_c) begin
                q.valid <= 1'b0;
                q.dirty <= 1'b0;
            end
        end
        assign lines[g] = q;
    end

    // R6: a cleared slot reads invalid on the following cycle
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr[0] && !we) |=> !lines[$past(cidx[0])].valid);
endmodule

// File: rtl/regcache_ctrl.sv
module regcache_ctrl
    import regcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  warp_t             wr_warp,
    input  rnum_t             wr_reg,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              rd_valid,
    input  warp_t             rd_warp,
    input  rnum_t             rd_reg0,
    input  rnum_t             rd_reg1,
    input  logic [1:0]        rd_last,
    output logic              ready,
    output logic              rd_done,
    output logic [LINE_W-1:0] rd_data0,
    output logic [LINE_W-1:0] rd_data1,
    output logic              bf_req,
    output logic              bf_we,
    output logic [ADDR_W-1:0] bf_addr,
    output logic [LINE_W-1:0] bf_wdata,
    input  logic              bf_ack,
    input  logic [LINE_W-1:0] bf_rdata,
    input  line_t             lines [SETS],
    output logic              st_we,
    output idx_t              st_widx,
    output line_t             st_wline,
    output logic [1:0]        st_clr,
    output idx_t [1:0]        st_cidx,
    output logic              wb_inc,
    output logic [1:0]        avoid_n
);
    st_t                    st;
    logic                   is_wr;
    logic                   op;
    warp_t                  q_warp;
    rnum_t [1:0]            q_rn;
    logic [1:0]             q_last;
    logic [LINE_W-1:0]      q_wdata;
    logic [1:0][LINE_W-1:0] cap;

    rnum_t cur_reg;
    idx_t  cur_idx, in_idx, idx0, idx1;
    line_t vic, in_line, l0, l1;
    logic  hit, vic_dirty, in_hit, in_block, c0, c1;

    always_comb begin
        cur_reg   = is_wr ? q_rn[0] : q_rn[op];
        cur_idx   = set_of(q_warp, cur_reg);
        vic       = lines[cur_idx];
        hit       = holds(vic, q_warp, cur_reg);
        vic_dirty = vic.valid && vic.dirty;
        in_idx    = set_of(wr_warp, wr_reg);
        in_line   = lines[in_idx];
        in_hit    = holds(in_line, wr_warp, wr_reg);
        in_block  = in_line.valid && in_line.dirty && !in_hit;
        idx0      = set_of(q_warp, q_rn[0]);
        idx1      = set_of(q_warp, q_rn[1]);
        l0        = lines[idx0];
        l1        = lines[idx1];
        c0        = q_last[0] && holds(l0, q_warp, q_rn[0]);
        c1        = q_last[1] && holds(l1, q_warp, q_rn[1]) && !(c0 && idx0 == idx1);
    end

    always_comb begin
        ready    = (st == ST_IDLE);
        rd_done  = (st == ST_FIN);
        rd_data0 = cap[0];
        rd_data1 = cap[1];
        bf_req   = 1'b0;
        bf_we    = 1'b0;
        bf_addr  = {q_warp, cur_reg};
        bf_wdata = '0;
        st_we    = 1'b0;
        st_widx  = cur_idx;
        st_wline = '0;
        st_clr   = 2'b00;
        st_cidx  = {idx1, idx0};
        wb_inc   = 1'b0;
        avoid_n  = 2'd0;
        case (st)
            ST_IDLE: begin
                if (wr_valid && !in_block) begin
                    st_we    = 1'b1;
                    st_widx  = in_idx;
                    st_wline = '{valid: 1'b1, dirty: 1'b1, warp: wr_warp,
                                 rnum: wr_reg, data: wr_data};
                end
            end
            ST_WB: begin
                bf_req   = 1'b1;
                bf_we    = 1'b1;
                bf_addr  = {vic.warp, vic.rnum};
                bf_wdata = vic.data;
                wb_inc   = bf_ack;
                if (bf_ack && is_wr) begin
                    st_we    = 1'b1;
                    st_wline = '{valid: 1'b1, dirty: 1'b1, warp: q_warp,
                                 rnum: q_rn[0], data: q_wdata};
                end
            end
            ST_FILL: begin
                bf_req = 1'b1;
                if (bf_ack) begin
                    st_we    = 1'b1;
                    st_wline = '{valid: 1'b1, dirty: 1'b0, warp: q_warp,
                                 rnum: cur_reg, data: bf_rdata};
                end
            end
            ST_FIN: begin
                st_clr  = {c1, c0};
                avoid_n = 2'(c0 && l0.dirty) + 2'(c1 && l1.dirty);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            is_wr   <= 1'b0;
            op      <= 1'b0;
            q_warp  <= '0;
            q_rn    <= '0;
            q_last  <= '0;
            q_wdata <= '0;
            cap     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (wr_valid) begin
                        is_wr   <= 1'b1;
                        q_warp  <= wr_warp;
                        q_rn[0] <= wr_reg;
                        q_wdata <= wr_data;
                        if (in_block) st <= ST_WB;
                    end else if (rd_valid) begin
                        is_wr  <= 1'b0;
                        op     <= 1'b0;
                        q_warp <= rd_warp;
                        q_rn   <= {rd_reg1, rd_reg0};
                        q_last <= rd_last;
                        st     <= ST_OP;
                    end
                end
                ST_OP: begin
                    if (hit) begin
                        cap[op] <= vic.data;
                        if (op) st <= ST_FIN;
                        else    op <= 1'b1;
                    end else begin
                        st <= vic_dirty ? ST_WB : ST_FILL;
                    end
                end
                ST_WB:   if (bf_ack) st <= is_wr ? ST_IDLE : ST_FILL;
                ST_FILL: if (bf_ack) st <= ST_OP;
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (bf_req && !bf_ack) |=> (bf_req && $stable(bf_addr)));
    a_r8_busy_while_req: assert property (@(posedge clk) disable iff (rst)
        bf_req |-> !ready);
    a_r3_wb_only_dirty: assert property (@(posedge clk) disable iff (rst)
        (bf_req && bf_we) |-> (lines[cur_idx].valid && lines[cur_idx].dirty));
    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> ready);
    a_r2_hit_write_local: assert property (@(posedge clk) disable iff (rst)
        (ready && wr_valid && in_hit) |=> !bf_req);
endmodule

// File: rtl/regcache_perf.sv
module regcache_perf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wb_inc,
    input  logic [1:0]       avoid_n,
    output logic [CNT_W-1:0] wb_count,
    output logic [CNT_W-1:0] wb_avoided
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_count   <= '0;
            wb_avoided <= '0;
        end else begin
            if (wb_inc) wb_count <= wb_count + 1'b1;
            wb_avoided <= wb_avoided + CNT_W'(avoid_n);
        end
    end

    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        wb_inc |=> (wb_count == CNT_W'($past(wb_count) + 1'b1)));
    a_r7_avoid_bounded: assert property (@(posedge clk) disable iff (rst)
        (avoid_n != 2'd0) |=> (wb_avoided != $past(wb_avoided)));
endmodule

// File: rtl/regcache_dvi.sv
module regcache_dvi
    import regcache_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [WARP_W-1:0] wr_warp,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [WARP_W-1:0] rd_warp,
    input  logic [REG_W-1:0]  rd_reg0,
    input  logic [REG_W-1:0]  rd_reg1,
    input  logic [1:0]        rd_last,
    output logic              ready,
    output logic              rd_done,
    output logic [LINE_W-1:0] rd_data0,
    output logic [LINE_W-1:0] rd_data1,
    output logic              bf_req,
    output logic              bf_we,
    output logic [ADDR_W-1:0] bf_addr,
    output logic [LINE_W-1:0] bf_wdata,
    input  logic              bf_ack,
    input  logic [LINE_W-1:0] bf_rdata,
    output logic [CNT_W-1:0]  wb_count,
    output logic [CNT_W-1:0]  wb_avoided
);
    line_t      lines [SETS];
    logic       st_we;
    idx_t       st_widx;
    line_t      st_wline;
    logic [1:0] st_clr;
    idx_t [1:0] st_cidx;
    logic       wb_inc;
    logic [1:0] avoid_n;

    regcache_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (st_we),
        .widx  (st_widx),
        .wline (st_wline),
        .clr   (st_clr),
        .cidx  (st_cidx),
        .lines (lines)
    );

    regcache_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_warp  (wr_warp),
        .wr_reg   (wr_reg),
        .wr_data  (wr_data),
        .rd_valid (rd_valid),
        .rd_warp  (rd_warp),
        .rd_reg0  (rd_reg0),
        .rd_reg1  (rd_reg1),
        .rd_last  (rd_last),
        .ready    (ready),
        .rd_done  (rd_done),
        .rd_data0 (rd_data0),
        .rd_data1 (rd_data1),
        .bf_req   (bf_req),
        .bf_we    (bf_we),
        .bf_addr  (bf_addr),
        .bf_wdata (bf_wdata),
        .bf_ack   (bf_ack),
        .bf_rdata (bf_rdata),
        .lines    (lines),
        .st_we    (st_we),
        .st_widx  (st_widx),
        .st_wline (st_wline),
        .st_clr   (st_clr),
        .st_cidx  (st_cidx),
        .wb_inc   (wb_inc),
        .avoid_n  (avoid_n)
    );

    regcache_perf #(.CNT_W(CNT_W)) u_perf (
        .clk        (clk),
        .rst        (rst),
        .wb_inc     (wb_inc),
        .avoid_n    (avoid_n),
        .wb_count   (wb_count),
        .wb_avoided (wb_avoided)
    );
endmodule

// File: tb/regcache_dvi_test.sv
module regcache_dvi_test;
    localparam int NSETS = 8;
    localparam int LAT   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_warp = '0;
    logic [3:0]  wr_reg = '0;
    logic [63:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [1:0]  rd_warp = '0;
    logic [3:0]  rd_reg0 = '0, rd_reg1 = '0;
    logic [1:0]  rd_last = '0;
    logic        ready, rd_done, bf_req, bf_we;
    logic [63:0] rd_data0, rd_data1, bf_wdata;
    logic [5:0]  bf_addr;
    logic        bf_ack = 1'b0;
    logic [63:0] bf_rdata = '0;
    logic [15:0] wb_count, wb_avoided;

    int n_chk = 0, n_fail = 0;
    int n_wb = 0, n_fill = 0, e_wb = 0, e_av = 0, e_fill = 0, busy_bad = 0;
    int cnt = 0;
    logic [63:0] bmem [64];
    logic [63:0] rmem [64];
    bit          rv [NSETS];
    bit          rdy [NSETS];
    logic [5:0]  rtag [NSETS];
    logic [63:0] rdat [NSETS];

    always #2 clk = ~clk;

    regcache_dvi uut (.*);

    function automatic logic [63:0] seed_val(int a);
        return {32'hB0B0_0000 | 32'(a), 32'h5EED_0000 | 32'(a * 7)};
    endfunction

    function automatic int sidx(logic [1:0] w, logic [3:0] r);
        return int'(r[2:0] ^ {1'b0, w});
    endfunction

    // backing register file with fixed latency
    always @(posedge clk) begin
        if (rst) begin
            bf_ack <= 1'b0;
            cnt    <= 0;
        end else if (bf_ack) begin
            bf_ack <= 1'b0;
        end else if (bf_req) begin
            if (cnt == LAT - 1) begin
                cnt    <= 0;
                bf_ack <= 1'b1;
                if (bf_we) begin
                    bmem[bf_addr] <= bf_wdata;
                    n_wb <= n_wb + 1;
                end else begin
                    bf_rdata <= bmem[bf_addr];
                    n_fill   <= n_fill + 1;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    always @(negedge clk) if (!rst && bf_req && ready) busy_bad <= busy_bad + 1;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ref_write(input logic [1:0] w, input logic [3:0] r, input logic [63:0] d);
        int s = sidx(w, r);
        if (!(rv[s] && rtag[s] == {w, r}) && rv[s] && rdy[s]) begin
            rmem[rtag[s]] = rdat[s];
            e_wb++;
        end
        rv[s] = 1; rdy[s] = 1; rtag[s] = {w, r}; rdat[s] = d;
    endtask

    task automatic ref_access(input logic [1:0] w, input logic [3:0] r, output logic [63:0] v);
        int s = sidx(w, r);
        if (!(rv[s] && rtag[s] == {w, r})) begin
            if (rv[s] && rdy[s]) begin
                rmem[rtag[s]] = rdat[s];
                e_wb++;
            end
            e_fill++;
            rv[s] = 1; rdy[s] = 0; rtag[s] = {w, r}; rdat[s] = rmem[{w, r}];
        end
        v = rdat[s];
    endtask

    task automatic ref_read(input logic [1:0] w, input logic [3:0] r0, input logic [3:0] r1,
                            input logic [1:0] lst, output logic [63:0] v0, output logic [63:0] v1);
        ref_access(w, r0, v0);
        ref_access(w, r1, v1);
        for (int i = 0; i < 2; i++) begin
            logic [3:0] r = (i == 0) ? r0 : r1;
            int s = sidx(w, r);
            if (lst[i] && rv[s] && rtag[s] == {w, r}) begin
                if (rdy[s]) e_av++;
                rv[s] = 0; rdy[s] = 0;
            end
        end
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " wb_count"}, wb_count, 16'(e_wb));
        chk({tag, " wb_avoided"}, wb_avoided, 16'(e_av));
        chk({tag, " backing writes"}, n_wb, e_wb);
        chk({tag, " backing fills"}, n_fill, e_fill);
    endtask

    task automatic do_write(input logic [1:0] w, input logic [3:0] r, input logic [63:0] d,
                            input string tag);
        @(negedge clk);
        while (!ready) @(negedge clk);
        wr_valid = 1; wr_warp = w; wr_reg = r; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
        ref_write(w, r, d);
        while (!ready) @(negedge clk);
        chk_counts(tag);
    endtask

    task automatic do_read(input logic [1:0] w, input logic [3:0] r0, input logic [3:0] r1,
                           input logic [1:0] lst, input string tag);
        logic [63:0] v0, v1;
        @(negedge clk);
        while (!ready) @(negedge clk);
        rd_valid = 1; rd_warp = w; rd_reg0 = r0; rd_reg1 = r1; rd_last = lst;
        @(negedge clk);
        rd_valid = 0;
        ref_read(w, r0, r1, lst, v0, v1);
        while (!rd_done) @(negedge clk);
        chk({tag, " operand0"}, rd_data0, v0);
        chk({tag, " operand1"}, rd_data1, v1);
        @(negedge clk);
        chk_counts(tag);
    endtask

    // R9: write and read raised together, same register
    task automatic do_both(input logic [1:0] w, input logic [3:0] r, input logic [63:0] d);
        logic [63:0] v0, v1;
        @(negedge clk);
        while (!ready) @(negedge clk);
        wr_valid = 1; wr_warp = w; wr_reg = r; wr_data = d;
        rd_valid = 1; rd_warp = w; rd_reg0 = r; rd_reg1 = r; rd_last = 2'b00;
        @(negedge clk);
        wr_valid = 0;
        ref_write(w, r, d);
        while (!ready) @(negedge clk);
        @(negedge clk);
        rd_valid = 0;
        ref_read(w, r, r, 2'b00, v0, v1);
        while (!rd_done) @(negedge clk);
        chk("R9 read after write operand0", rd_data0, v0);
        chk("R9 read after write operand1", rd_data1, d);
        @(negedge clk);
        chk_counts("R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        for (int a = 0; a < 64; a++) begin
            bmem[a] = seed_val(a);
            rmem[a] = seed_val(a);
        end
        for (int s = 0; s < NSETS; s++) begin
            rv[s] = 0; rdy[s] = 0; rtag[s] = '0; rdat[s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", ready, 1'b1);
        chk("R1 bf_req", bf_req, 1'b0);
        chk("R1 wb_count", wb_count, 16'd0);
        chk("R1 wb_avoided", wb_avoided, 16'd0);

        // R2 write then hit
        do_write(2'd0, 4'd3, 64'hA1A1_0000_0000_00A1, "R2 write");
        do_read(2'd0, 4'd3, 4'd3, 2'b00, "R2 hit read");
        // R5 collision: set 3 shared by (0,3) and (1,2)
        do_write(2'd1, 4'd2, 64'hB2B2_0000_0000_00B2, "R5 collide write R3");
        chk("R5 evicted value in backing", bmem[{2'd0, 4'd3}], 64'hA1A1_0000_0000_00A1);
        do_read(2'd0, 4'd3, 4'd3, 2'b00, "R4 fill after eviction R3");
        // R4 clean line evicted without write-back
        do_read(2'd0, 4'd9, 4'd9, 2'b00, "R4 fill");
        do_write(2'd0, 4'd1, 64'hC3C3_0000_0000_00C3, "R4 clean victim");
        // R6 dead dirty line dropped
        do_write(2'd2, 4'd5, 64'hD4D4_0000_0000_00D4, "R6 write");
        do_read(2'd2, 4'd5, 4'd6, 2'b01, "R6 last read");
        chk("R6 backing untouched", bmem[{2'd2, 4'd5}], seed_val({2'd2, 4'd5}));
        do_read(2'd2, 4'd5, 4'd5, 2'b00, "R6 refetch");
        // R7 same register twice, one flag
        do_write(2'd3, 4'd7, 64'hE5E5_0000_0000_00E5, "R7 write");
        do_read(2'd3, 4'd7, 4'd7, 2'b10, "R7 dup last");
        do_read(2'd3, 4'd7, 4'd7, 2'b11, "R7 dup both flags");
        // R10 operands in one set: operand 1 evicts operand 0
        do_write(2'd0, 4'd4, 64'hF6F6_0000_0000_00F6, "R10 write");
        do_read(2'd0, 4'd4, 4'd12, 2'b01, "R10 ordered operands");
        // R9 priority
        do_both(2'd1, 4'd4, 64'h9999_0000_0000_0099);

        for (int k = 0; k < 400; k++) begin
            logic [1:0]  w  = 2'($urandom_range(0, 3));
            logic [3:0]  r0 = 4'($urandom_range(0, 15));
            logic [3:0]  r1 = ($urandom_range(0, 3) == 0) ? r0 : 4'($urandom_range(0, 15));
            logic [1:0]  ls = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 0)
                do_write(w, r0, {$urandom, $urandom}, "R2 R3 random write");
            else
                do_read(w, r0, r1, ls, "R4 R6 R7 random read");
        end

        for (int a = 0; a < 64; a++) chk("R3 backing contents", bmem[a], rmem[a]);
        chk("R8 ready low during request", busy_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule